// File: doc/BRIEF.md
# Serial EEPROM Write-Protect and Status Controller

This block sits behind the command decoder of a serial EEPROM. It keeps the write-enable latch, the two protection-level bits and the programming-busy flag. It decides, one request at a time, whether an array write or a protection update may go ahead, and it forms the status byte that the serial front end shifts out when status is read. Serial shifting and the memory array are handled elsewhere. The decoder delivers each command as a single-cycle pulse, and the array reports the end of programming with a one-cycle completion pulse.

Every input is a plain control pulse or level, and every output is a plain registered or decoded state. There is no valid/ready handshake. A command pulse is taken in the cycle it is high and is never back-pressured. A command that cannot be honoured, because the part is busy, the latch is clear, the protect pin is low or the address is guarded, is simply dropped. State changes on the clock edge that samples a command and is visible on the outputs right after that edge. The grant pulse is registered and appears for one cycle after the accepted request.

Top module: `eewp_ctrl`

## Requirements
- R1: After reset, `status_o` is 0x00, `bp_o` is 00 and `wr_grant_o` is 0, so the part is write-disabled and idle.
- R2: While idle, a `wren_i` pulse sets the enable latch (status bit 1) and a `wrdi_i` pulse clears it. Both are ignored while busy.
- R3: An accepted write pulses `wr_grant_o` for exactly one cycle after the request and makes the part busy. Busy lasts until `prog_done_i`, and that completion also clears the enable latch.
- R4: When idle, the status byte holds RDY=0 in bit 0, the enable latch in bit 1, BP0 in bit 2 and BP1 in bit 3. Bits 7 to 4 read 0.
- R5: The level {BP1,BP0} guards addresses as follows: 00 guards none, 01 guards 0x180–0x1FF, 10 guards 0x100–0x1FF and 11 guards 0x000–0x1FF. A write to a guarded address is refused.
- R6: While busy, the status byte reads 0xFF (RDY=1 and every other bit forced to 1).
- R7: A write is granted only when `wp_pin_i` is high, the latch is set, the part is idle and the address is unguarded. A refused write gives no grant, starts no busy cycle and leaves the latch unchanged.
- R8: A protection update takes `wrsr_data_i[3]` as BP1 and `wrsr_data_i[2]` as BP0 and ignores the other bits. It needs `wp_pin_i` high, the latch set and the part idle. It gives no grant pulse but starts a busy cycle, whose completion clears the latch. A refused update changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wren_i | input | 1 | Set-enable command pulse |
| wrdi_i | input | 1 | Clear-enable command pulse |
| wrsr_i | input | 1 | Protection-update command pulse |
| wrsr_data_i | input | 8 | Status byte sent with the update; bits 3:2 are used |
| wr_req_i | input | 1 | Array-write request pulse |
| wr_addr_i | input | 9 | Target byte address of the write |
| prog_done_i | input | 1 | Programming-complete pulse from the array |
| wp_pin_i | input | 1 | Write-protect pin; high allows programming |
| status_o | output | 8 | Status byte for a status read |
| wr_grant_o | output | 1 | One-cycle permit for an accepted array write |
| bp_o | output | 2 | Current protection level {BP1,BP0} |

## Verification
The assertions assume that the decoder raises at most one command pulse per cycle, and that `prog_done_i` arrives only while a programming cycle is in flight. The stimulus keeps to both rules. Directed sequences issue a single command per cycle, and the randomized phase draws one command per cycle and raises completion only while the bench's own model reports busy. Within these limits the properties check the latch transitions, busy hold and release, the all-ones status while busy, protection-level stability and refusal under a low pin or full protection.

// File: rtl/eewp_pkg.sv
`timescale 1ns/1ps
package eewp_pkg;
  localparam int STATUS_W = 8;
  localparam int LEVEL_W  = 2;

  typedef enum logic [LEVEL_W-1:0] {
    PROT_NONE = 2'b00,
    PROT_QTR  = 2'b01,
    PROT_HALF = 2'b10,
    PROT_ALL  = 2'b11
  } prot_lvl_e;

  typedef struct packed {
    logic       busy;
    logic       wel;
    prot_lvl_e  lvl;
  } ctrl_state_t;
endpackage

// File: rtl/eewp_enable_latch.sv
`timescale 1ns/1ps
module eewp_enable_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic done_i,
  input  logic busy_i,
  output logic wel_o
);
  logic wel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wel_q <= 1'b0;
    end else if (busy_i) begin
      if (done_i) wel_q <= 1'b0;
    end else if (clr_i) begin
      wel_q <= 1'b0;
    end else if (set_i) begin
      wel_q <= 1'b1;
    end
  end

  assign wel_o = wel_q;

  a_r2_set_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !clr_i && !busy_i) |=> wel_o);
  a_r2_clear_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !busy_i) |=> !wel_o);
  a_r2_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !done_i) |=> $stable(wel_o));
  a_r3_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && done_i) |=> !wel_o);
endmodule

// File: rtl/eewp_prot_check.sv
`timescale 1ns/1ps
module eewp_prot_check
  import eewp_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  prot_lvl_e         lvl_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              guarded_o
);
  logic in_top_quarter;
  logic in_top_half;

  generate
    if (ADDR_W >= 2) begin : g_wide
      assign in_top_quarter = &addr_i[ADDR_W-1 -: 2];
      assign in_top_half    = addr_i[ADDR_W-1];
    end else begin : g_narrow
      assign in_top_quarter = addr_i[0];
      assign in_top_half    = addr_i[0];
    end
  endgenerate

  always_comb begin
    unique case (lvl_i)
      PROT_NONE: guarded_o = 1'b0;
      PROT_QTR:  guarded_o = in_top_quarter;
      PROT_HALF: guarded_o = in_top_half;
      default:   guarded_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/eewp_prog_tracker.sv
`timescale 1ns/1ps
module eewp_prog_tracker
  import eewp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_ok_i,
  input  logic      sr_ok_i,
  input  prot_lvl_e sr_lvl_i,
  input  logic      done_i,
  output logic      busy_o,
  output prot_lvl_e lvl_o,
  output logic      grant_o
);
  logic      busy_q;
  prot_lvl_e lvl_q;
  logic      grant_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      lvl_q   <= PROT_NONE;
      grant_q <= 1'b0;
    end else begin
      grant_q <= wr_ok_i;
      if (busy_q) begin
        if (done_i) busy_q <= 1'b0;
      end else if (wr_ok_i || sr_ok_i) begin
        busy_q <= 1'b1;
      end
      if (sr_ok_i) lvl_q <= sr_lvl_i;
    end
  end

  assign busy_o  = busy_q;
  assign lvl_o   = lvl_q;
  assign grant_o = grant_q;

  a_r3_grant_single: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o |=> !grant_o);
  a_r3_grant_busy: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o |-> busy_o);
  a_r3_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_i) |=> busy_o);
  a_r8_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sr_ok_i |=> $stable(lvl_o));
endmodule

// File: rtl/eewp_status_fmt.sv
`timescale 1ns/1ps
module eewp_status_fmt
  import eewp_pkg::*;
(
  input  logic                busy_i,
  input  logic                wel_i,
  input  prot_lvl_e           lvl_i,
  output logic [STATUS_W-1:0] status_o
);
  localparam int PAD_W = STATUS_W - 2 - LEVEL_W;

  always_comb begin
    if (busy_i) status_o = '1;
    else        status_o = {{PAD_W{1'b0}}, lvl_i, wel_i, 1'b0};
  end
endmodule

// File: rtl/eewp_ctrl.sv
`timescale 1ns/1ps
module eewp_ctrl
  import eewp_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wren_i,
  input  logic              wrdi_i,
  input  logic              wrsr_i,
  input  logic [7:0]        wrsr_data_i,
  input  logic              wr_req_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              prog_done_i,
  input  logic              wp_pin_i,
  output logic [7:0]        status_o,
  output logic              wr_grant_o,
  output logic [1:0]        bp_o
);
  logic      busy;
  logic      wel;
  logic      guarded;
  logic      prog_allowed;
  logic      wr_ok;
  logic      sr_ok;
  prot_lvl_e lvl;
  prot_lvl_e sr_lvl;

  assign prog_allowed = !busy && wel && wp_pin_i;
  assign wr_ok  = wr_req_i && prog_allowed && !guarded;
  assign sr_ok  = wrsr_i && prog_allowed;
  assign sr_lvl = prot_lvl_e'(wrsr_data_i[3:2]);

  eewp_enable_latch u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (wren_i),
    .clr_i  (wrdi_i),
    .done_i (prog_done_i),
    .busy_i (busy),
    .wel_o  (wel)
  );

  eewp_prot_check #(.ADDR_W(ADDR_W)) u_prot (
    .lvl_i     (lvl),
    .addr_i    (wr_addr_i),
    .guarded_o (guarded)
  );

  eewp_prog_tracker u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_ok_i  (wr_ok),
    .sr_ok_i  (sr_ok),
    .sr_lvl_i (sr_lvl),
    .done_i   (prog_done_i),
    .busy_o   (busy),
    .lvl_o    (lvl),
    .grant_o  (wr_grant_o)
  );

  eewp_status_fmt u_fmt (
    .busy_i   (busy),
    .wel_i    (wel),
    .lvl_i    (lvl),
    .status_o (status_o)
  );

  assign bp_o = lvl;

  a_r6_busy_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (status_o == 8'hFF));
  a_r4_idle_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (status_o[7:4] == 4'h0 && !status_o[0]));
  a_r7_pin_low_refuses: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req_i && !wp_pin_i) |=> !wr_grant_o);
  a_r7_no_latch_refuses: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req_i && !status_o[1]) |=> !wr_grant_o);
  a_r5_full_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req_i && bp_o == 2'b11) |=> !wr_grant_o);
  a_r8_pin_low_keeps_level: assert property (@(posedge clk) disable iff (!rst_n)
    !wp_pin_i |=> $stable(bp_o));
endmodule

// File: tb/eewp_ctrl_bench.sv
`timescale 1ns/1ps
module eewp_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wren_i = 0, wrdi_i = 0, wrsr_i = 0, wr_req_i = 0, prog_done_i = 0;
  logic       wp_pin_i = 1'b1;
  logic [7:0] wrsr_data_i = '0;
  logic [8:0] wr_addr_i = '0;
  logic [7:0] status_o;
  logic       wr_grant_o;
  logic [1:0] bp_o;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  // behavioural reference state
  int m_wel = 0, m_busy = 0, m_lvl = 0, m_grant = 0;

  always #5 clk = ~clk;

  eewp_ctrl u_eewp_ctrl (
    .clk(clk), .rst_n(rst_n), .wren_i(wren_i), .wrdi_i(wrdi_i),
    .wrsr_i(wrsr_i), .wrsr_data_i(wrsr_data_i), .wr_req_i(wr_req_i),
    .wr_addr_i(wr_addr_i), .prog_done_i(prog_done_i), .wp_pin_i(wp_pin_i),
    .status_o(status_o), .wr_grant_o(wr_grant_o), .bp_o(bp_o)
  );

  function automatic int guarded(int lvl, int addr);
    case (lvl)
      0: return 0;
      1: return (addr >= 'h180) ? 1 : 0;
      2: return (addr >= 'h100) ? 1 : 0;
      default: return 1;
    endcase
  endfunction

  function automatic int exp_status();
    if (m_busy != 0) return 'hFF;
    return (m_lvl << 2) | (m_wel << 1);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic en, input logic dis, input logic sr,
                      input logic [7:0] d, input logic wr, input logic [8:0] a,
                      input logic dn);
    int ok;
    @(negedge clk);
    wren_i = en; wrdi_i = dis; wrsr_i = sr; wrsr_data_i = d;
    wr_req_i = wr; wr_addr_i = a; prog_done_i = dn;
    @(posedge clk);
    m_grant = 0;
    if (!rst_n) begin
      m_wel = 0; m_busy = 0; m_lvl = 0;
    end else if (m_busy != 0) begin
      if (dn) begin m_busy = 0; m_wel = 0; end
    end else begin
      ok = (wp_pin_i && m_wel != 0) ? 1 : 0;
      if (dis) m_wel = 0;
      else if (en) m_wel = 1;
      if (sr && ok != 0) begin m_lvl = int'(d[3:2]); m_busy = 1; end
      if (wr && ok != 0 && guarded(m_lvl, int'(a)) == 0) begin
        m_grant = 1; m_busy = 1;
      end
    end
    #1;
    chk((m_busy != 0) ? "R6 status" : "R4 status", int'(status_o), exp_status());
    chk("R7 grant", int'(wr_grant_o), m_grant);
    chk("R8 level", int'(bp_o), m_lvl);
  endtask

  task automatic nop();               step(0,0,0,8'h00,0,9'h000,0); endtask
  task automatic do_wren();           step(1,0,0,8'h00,0,9'h000,0); endtask
  task automatic do_wrdi();           step(0,1,0,8'h00,0,9'h000,0); endtask
  task automatic do_wrsr(input logic [7:0] d); step(0,0,1,d,0,9'h000,0); endtask
  task automatic do_wr(input logic [8:0] a);   step(0,0,0,8'h00,1,a,0); endtask
  task automatic do_done();           step(0,0,0,8'h00,0,9'h000,1); endtask

  // set latch, attempt write at address, expect grant value, finish if busy
  task automatic try_write(input logic [8:0] a, input int exp_g, input string tag);
    do_wren();
    do_wr(a);
    chk(tag, int'(wr_grant_o), exp_g);
    if (m_busy != 0) begin nop(); do_done(); end
    else do_wrdi();
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) nop();
    rst_n = 1'b1;
    // R1: reset state
    chk("R1 status", int'(status_o), 'h00);
    chk("R1 level", int'(bp_o), 0);
    chk("R1 grant", int'(wr_grant_o), 0);

    // R7: write without latch is refused
    do_wr(9'h010);
    chk("R7 no latch", int'(wr_grant_o), 0);
    chk("R7 no busy", int'(status_o), 'h00);

    // R2: set and clear
    do_wren();
    chk("R2 set", int'(status_o), 'h02);
    do_wrdi();
    chk("R2 clear", int'(status_o), 'h00);

    // R7: pin low refuses, latch kept
    do_wren();
    wp_pin_i = 1'b0;
    do_wr(9'h020);
    chk("R7 pin low grant", int'(wr_grant_o), 0);
    chk("R7 latch kept", int'(status_o), 'h02);
    wp_pin_i = 1'b1;

    // R3/R6: accepted write
    do_wr(9'h1FF);
    chk("R3 grant", int'(wr_grant_o), 1);
    chk("R6 busy", int'(status_o), 'hFF);
    nop();
    chk("R3 grant one cycle", int'(wr_grant_o), 0);
    do_wrdi();
    do_wren();
    chk("R2 ignored while busy", int'(status_o), 'hFF);
    do_done();
    chk("R3 done clears latch", int'(status_o), 'h00);

    // R8: update refused without latch, then accepted
    do_wrsr(8'h0C);
    chk("R8 refused", int'(bp_o), 0);
    do_wren();
    do_wrsr(8'h04);
    chk("R8 busy", int'(status_o), 'hFF);
    chk("R8 no grant", int'(wr_grant_o), 0);
    do_done();
    chk("R4 layout BP0", int'(status_o), 'h04);

    // R5: quarter guard
    try_write(9'h180, 0, "R5 qtr 0x180");
    try_write(9'h17F, 1, "R5 qtr 0x17F");
    do_wren(); do_wrsr(8'h08); do_done();
    chk("R4 layout BP1", int'(status_o), 'h08);
    try_write(9'h100, 0, "R5 half 0x100");
    try_write(9'h0FF, 1, "R5 half 0x0FF");
    do_wren(); do_wrsr(8'h0C); do_done();
    try_write(9'h000, 0, "R5 all 0x000");
    // R8: other bits ignored, level back to none
    do_wren(); do_wrsr(8'hF3); do_done();
    chk("R8 bits ignored", int'(bp_o), 0);
    try_write(9'h1FF, 1, "R5 none 0x1FF");

    // randomized phase, one command per cycle
    for (int i = 0; i < 600; i++) begin
      int r;
      logic [8:0] a;
      logic [7:0] d;
      r = int'($urandom % 8);
      a = 9'($urandom);
      d = 8'($urandom);
      wp_pin_i = ($urandom % 5) != 0;
      if (m_busy != 0 && r < 3) do_done();
      else case (r)
        0, 1: do_wren();
        2:    do_wrdi();
        3:    do_wrsr(d);
        4, 5: do_wr(a);
        default: nop();
      endcase
    end
    if (m_busy != 0) do_done();

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule